// File: doc/BRIEF.md
# UART Transmit Status Flag Controller

This block owns the two transmitter status bits of a UART whose one-entry transmit holding buffer feeds a serial shifter. The first bit is buffer-empty and the second is transmit-complete. Software sees them in a status register. The block takes these inputs:

- a strobe for each status-register read;
- a strobe for each data-register write, with its data;
- the transmit-enable level;
- a strobe for each write of 1 to the send-break bit;
- the character-length bit;
- the shifter's idle indication.

The block holds the buffered character. It also holds a queued preamble (an all-ones idle character) and a queued break (an all-zeros character). It hands each one to the shifter with a one-cycle load request and a 2-bit code.

A flag is not cleared by a single access. A status read must first see the flag at 1, which arms that flag. A later qualifying action then clears it. For buffer-empty, the qualifying action is a data write that finds the buffer free. For transmit-complete, it is a data write, a 0-to-1 change of transmit enable, or a send-break write. Each action uses up the arming, whether it clears the flag or not.

The asynchronous active-low reset is released through a two-stage synchronizer. The block therefore leaves reset two clock edges after `rst_n` rises.

Top module: `uart_txst_ctrl`

## Requirements
- R1: After reset, `buf_empty` = 1, `tx_done` = 1 and `ld_req` = 0.
- R2: A status read that sees `buf_empty` = 1, followed by a data write while the buffer is unoccupied, makes `buf_empty` read 0 in the cycle after the write.
- R3: A data write always stores its data in the buffer. A write that replaces data not yet loaded into the shifter, or a write with no arming read, leaves `buf_empty` unchanged.
- R4: When transmit enable is 1, the shifter is idle, no load is awaiting the shifter's busy response and the buffer is occupied, `ld_req` pulses for exactly one cycle with `ld_code` = 2'b01 and the buffered data. `buf_empty` reads 1 in the cycle after that pulse.
- R5: A 0-to-1 change of `tx_en` queues a preamble, which is loaded with `ld_code` = 2'b10.
- R6: A send-break write queues a break, which is loaded with `ld_code` = 2'b11.
- R7: When several items wait, they are loaded in this order: preamble first, then break, then buffered data.
- R8: A status read that sees `tx_done` = 1, followed by one of the three qualifying actions, makes `tx_done` read 0 in the cycle after that action.
- R9: Without an arming read, none of the qualifying actions clears `tx_done`.
- R10: `tx_done` returns to 1 when the buffer is empty, nothing is queued or awaiting the shifter, and the shifter reports idle.
- R11: A qualifying action uses up the arming of the flags it acts on. A later action clears nothing until a new status read sees the flag at 1.
- R12: No load request is made while `tx_en` = 0.
- R13: `ld_len` gives the character length of every load: 10 when `char_long` = 0 and 11 when `char_long` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd | input | 1 | Status-register read strobe |
| data_wr | input | 1 | Data-register write strobe |
| data_wdata | input | DW | Data written to the buffer |
| tx_en | input | 1 | Transmit enable level |
| brk_wr | input | 1 | Strobe for a write of 1 to send-break |
| char_long | input | 1 | Character-length select (0: 10 bits, 1: 11 bits) |
| shf_idle | input | 1 | Shifter idle; must drop the cycle after a load |
| buf_empty | output | 1 | Buffer-empty status flag |
| tx_done | output | 1 | Transmit-complete status flag |
| ld_req | output | 1 | One-cycle load request to the shifter |
| ld_code | output | 2 | Load kind: 01 data, 10 preamble, 11 break |
| ld_data | output | DW | Character handed to the shifter |
| ld_len | output | LENW | Character length in bit times |

## Verification
Both flags are registered. A read or action sampled at one rising edge therefore shows at the flags from that edge on, and the bench checks them at the next falling edge after driving the strobe. The load request is combinational on registered state and the shifter's idle input, so it can rise in the same cycle that the bench model frees the shifter. For that reason the scoreboard monitor samples it one nanosecond after each falling edge, when inputs have settled. A data load sets `buf_empty` in the cycle after the request, and the bench checks exactly one falling edge after it sees the pulse. Sequences that span shifter activity wait a fixed margin larger than the modelled shift time, then check that the expected queue has drained and that `tx_done` is set.

// File: rtl/uart_txst_pkg.sv
package uart_txst_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'b00,
    LD_DATA = 2'b01,
    LD_PRE  = 2'b10,
    LD_BRK  = 2'b11
  } ld_code_e;

  localparam int FLAG_BE = 0;
  localparam int FLAG_TD = 1;
  localparam int NFLAG   = 2;
endpackage

// File: rtl/uart_txst_rsync.sv
module uart_txst_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/uart_txst_arm.sv
module uart_txst_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic flag,
  input  logic consume,
  output logic armed
);
  logic armed_q, armed_n, armed_en;

  always_comb begin
    armed_en = consume | rd;
    armed_n  = consume ? 1'b0 : flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_n;
  end

  assign armed = armed_q;
endmodule

// File: rtl/uart_txst_queue.sv
module uart_txst_queue
  import uart_txst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] data_wdata,
  input  logic          tx_en,
  input  logic          brk_wr,
  input  logic          shf_idle,
  output logic          issue,
  output ld_code_e      issue_code,
  output logic [DW-1:0] issue_data,
  output logic          buf_full,
  output logic          en_rise,
  output logic          data_load,
  output logic          tx_idle
);
  logic [DW-1:0] buf_q;
  logic          full_q, full_n;
  logic          pre_q, pre_n;
  logic          brk_q, brk_n;
  logic          fly_q, fly_n;
  logic          en_q;
  logic          any_pend;

  always_comb begin
    en_rise  = tx_en & ~en_q;
    any_pend = pre_q | brk_q | full_q;
    issue    = tx_en & shf_idle & ~fly_q & any_pend;
    if (pre_q)      issue_code = LD_PRE;
    else if (brk_q) issue_code = LD_BRK;
    else            issue_code = LD_DATA;
    data_load = issue & (issue_code == LD_DATA);
    pre_n  = en_rise | (pre_q  & ~(issue & (issue_code == LD_PRE)));
    brk_n  = brk_wr  | (brk_q  & ~(issue & (issue_code == LD_BRK)));
    full_n = data_wr | (full_q & ~data_load);
    fly_n  = issue   | (fly_q  & shf_idle);
    tx_idle = ~full_q & ~pre_q & ~brk_q & ~fly_q & shf_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pre_q  <= 1'b0;
      brk_q  <= 1'b0;
      fly_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      full_q <= full_n;
      pre_q  <= pre_n;
      brk_q  <= brk_n;
      fly_q  <= fly_n;
      en_q   <= tx_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       buf_q <= '0;
    else if (data_wr) buf_q <= data_wdata;
  end

  assign issue_data = buf_q;
  assign buf_full   = full_q;
endmodule

// File: rtl/uart_txst_flags.sv
module uart_txst_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic be_set,
  input  logic be_clr,
  input  logic td_set,
  input  logic td_clr,
  output logic buf_empty,
  output logic tx_done
);
  logic be_q, be_n, td_q, td_n;

  always_comb begin
    if (be_set)      be_n = 1'b1;
    else if (be_clr) be_n = 1'b0;
    else             be_n = be_q;
    if (td_clr)      td_n = 1'b0;
    else if (td_set) td_n = 1'b1;
    else             td_n = td_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q <= 1'b1;
      td_q <= 1'b1;
    end else begin
      be_q <= be_n;
      td_q <= td_n;
    end
  end

  assign buf_empty = be_q;
  assign tx_done   = td_q;
endmodule

// File: rtl/uart_txst_ctrl.sv
module uart_txst_ctrl
  import uart_txst_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SHORT_LEN  = 10,
  parameter int LONG_LEN   = 11,
  parameter int RST_STAGES = 2,
  localparam int LENW      = $clog2(LONG_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_rd,
  input  logic            data_wr,
  input  logic [DW-1:0]   data_wdata,
  input  logic            tx_en,
  input  logic            brk_wr,
  input  logic            char_long,
  input  logic            shf_idle,
  output logic            buf_empty,
  output logic            tx_done,
  output logic            ld_req,
  output logic [1:0]      ld_code,
  output logic [DW-1:0]   ld_data,
  output logic [LENW-1:0] ld_len
);
  logic             rst_s;
  logic             issue, buf_full, en_rise, data_load, tx_idle;
  ld_code_e         issue_code;
  logic [DW-1:0]    issue_data;
  logic [NFLAG-1:0] flag_vec, consume_vec, armed_vec;
  logic             td_act, be_clr, td_clr;

  uart_txst_rsync #(.STAGES(RST_STAGES)) rsync_i (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s)
  );

  uart_txst_queue #(.DW(DW)) queue_i (
    .clk(clk), .rst_n(rst_s), .data_wr(data_wr), .data_wdata(data_wdata),
    .tx_en(tx_en), .brk_wr(brk_wr), .shf_idle(shf_idle),
    .issue(issue), .issue_code(issue_code), .issue_data(issue_data),
    .buf_full(buf_full), .en_rise(en_rise), .data_load(data_load),
    .tx_idle(tx_idle)
  );

  always_comb begin
    td_act                 = data_wr | en_rise | brk_wr;
    flag_vec[FLAG_BE]      = buf_empty;
    flag_vec[FLAG_TD]      = tx_done;
    consume_vec[FLAG_BE]   = data_wr;
    consume_vec[FLAG_TD]   = td_act;
    be_clr                 = armed_vec[FLAG_BE] & data_wr & ~buf_full;
    td_clr                 = armed_vec[FLAG_TD] & td_act;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_arm
    uart_txst_arm arm_i (
      .clk(clk), .rst_n(rst_s), .rd(stat_rd), .flag(flag_vec[g]),
      .consume(consume_vec[g]), .armed(armed_vec[g])
    );
  end

  uart_txst_flags flags_i (
    .clk(clk), .rst_n(rst_s),
    .be_set(data_load), .be_clr(be_clr),
    .td_set(tx_idle), .td_clr(td_clr),
    .buf_empty(buf_empty), .tx_done(tx_done)
  );

  assign ld_req  = issue;
  assign ld_code = issue ? issue_code : LD_NONE;
  assign ld_data = issue_data;
  assign ld_len  = char_long ? LENW'(LONG_LEN) : LENW'(SHORT_LEN);
endmodule

// File: rtl/uart_txst_ctrl_chk.sv
module uart_txst_ctrl_chk #(
  parameter int DW = 8
) (
  input logic       clk,
  input logic       rst_s,
  input logic       data_wr,
  input logic       tx_en,
  input logic       brk_wr,
  input logic       shf_idle,
  input logic       buf_empty,
  input logic       tx_done,
  input logic       ld_req,
  input logic [1:0] ld_code
);
  // R4: the load request lasts a single cycle
  a_r4_ld_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    ld_req |=> !ld_req);
  // R4: a request only goes to an idle shifter
  a_r4_ld_idle: assert property (@(posedge clk) disable iff (!rst_s)
    ld_req |-> shf_idle);
  // R4: a data load leaves the buffer-empty flag set
  a_r4_be_after_load: assert property (@(posedge clk) disable iff (!rst_s)
    (ld_req && ld_code == 2'b01) |=> buf_empty);
  // R2: buffer-empty falls only after a data write
  a_r2_be_fall: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(buf_empty) |-> $past(data_wr));
  // R8: transmit-complete falls only after a qualifying action
  a_r8_td_fall: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(tx_done) |-> $past(data_wr || brk_wr || tx_en));
  // R10: transmit-complete rises only with the shifter idle
  a_r10_td_rise: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(tx_done) |-> $past(shf_idle));
  // R12: nothing is loaded while transmit is disabled
  a_r12_no_load_off: assert property (@(posedge clk) disable iff (!rst_s)
    !tx_en |-> !ld_req);
  // R6: a request always carries a real code
  a_r6_code_valid: assert property (@(posedge clk) disable iff (!rst_s)
    ld_req |-> ld_code != 2'b00);
endmodule

bind uart_txst_ctrl uart_txst_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_s(rst_s), .data_wr(data_wr), .tx_en(tx_en),
  .brk_wr(brk_wr), .shf_idle(shf_idle), .buf_empty(buf_empty),
  .tx_done(tx_done), .ld_req(ld_req), .ld_code(ld_code)
);

// File: tb/uart_txst_ctrl_tb_top.sv
module uart_txst_ctrl_tb_top;
  localparam int DW   = 8;
  localparam int LENW = 4;
  localparam int SHIFT_CYC = 5;
  localparam logic [1:0] C_DATA = 2'b01, C_PRE = 2'b10, C_BRK = 2'b11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, stat_rd, data_wr, tx_en, brk_wr, char_long, shf_idle;
  logic [DW-1:0] data_wdata, ld_data;
  logic buf_empty, tx_done, ld_req;
  logic [1:0] ld_code;
  logic [LENW-1:0] ld_len;

  uart_txst_ctrl #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_wr(data_wr),
    .data_wdata(data_wdata), .tx_en(tx_en), .brk_wr(brk_wr),
    .char_long(char_long), .shf_idle(shf_idle), .buf_empty(buf_empty),
    .tx_done(tx_done), .ld_req(ld_req), .ld_code(ld_code),
    .ld_data(ld_data), .ld_len(ld_len)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [2+DW+LENW-1:0] exp_q[$];

  // shifter model: busy SHIFT_CYC cycles after each load
  int  sh_cnt;
  logic hold_busy;
  always @(posedge clk) begin
    if (!rst_n)            sh_cnt <= 0;
    else if (ld_req)       sh_cnt <= SHIFT_CYC;
    else if (sh_cnt != 0)  sh_cnt <= sh_cnt - 1;
  end
  assign shf_idle = (sh_cnt == 0) && !hold_busy;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ld(logic [1:0] code, logic [DW-1:0] d, logic lng);
    logic [LENW-1:0] len;
    len = lng ? LENW'(11) : LENW'(10);
    exp_q.push_back({code, d, len});
  endtask

  // monitor: compares every load against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && ld_req) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected load act=%0h exp=none", {ld_code, ld_data, ld_len});
      end else begin
        logic [2+DW+LENW-1:0] e;
        e = exp_q.pop_front();
        if ({ld_code, ld_data, ld_len} !== e) begin
          n_bad++;
          $display("FAIL R7 R13 load act=%0h exp=%0h", {ld_code, ld_data, ld_len}, e);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic rd_pulse();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask
  task automatic wr_pulse(logic [DW-1:0] d);
    data_wdata = d; data_wr = 1'b1; @(negedge clk); data_wr = 1'b0;
  endtask
  task automatic brk_pulse();
    brk_wr = 1'b1; @(negedge clk); brk_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int guard;
    rst_n = 1'b0; stat_rd = 1'b0; data_wr = 1'b0; data_wdata = '0;
    tx_en = 1'b0; brk_wr = 1'b0; char_long = 1'b0; hold_busy = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 tx_done", tx_done, 1);
    chk("R1 ld_req", ld_req, 0);

    // R3 R9 R12: write with transmit disabled and no arming read
    wr_pulse(8'hA5);
    chk("R3 buf_empty after plain write", buf_empty, 1);
    chk("R9 tx_done after plain write", tx_done, 1);
    cyc(6);
    #1 chk("R12 no load while disabled", ld_req, 0);
    @(negedge clk);

    // R5 R6 R7: preamble, break and data all waiting
    hold_busy = 1'b1;
    expect_ld(C_PRE, 8'hA5, 1'b0);
    expect_ld(C_BRK, 8'hA5, 1'b0);
    expect_ld(C_DATA, 8'hA5, 1'b0);
    tx_en = 1'b1; @(negedge clk);
    brk_pulse();
    hold_busy = 1'b0;
    cyc(60);
    chk("R7 queue drained", exp_q.size(), 0);
    chk("R10 tx_done idle", tx_done, 1);
    chk("R3 buf_empty unchanged", buf_empty, 1);

    // R2 R8 R4: armed read then data write
    hold_busy = 1'b1;
    rd_pulse();
    expect_ld(C_DATA, 8'h3C, 1'b0);
    wr_pulse(8'h3C);
    chk("R2 buf_empty cleared", buf_empty, 0);
    chk("R8 tx_done cleared by write", tx_done, 0);
    hold_busy = 1'b0;
    #1;
    guard = 0;
    while (!ld_req && guard < 50) begin @(negedge clk); #1; guard++; end
    @(negedge clk);
    chk("R4 buf_empty after load", buf_empty, 1);
    #1 chk("R4 single-cycle request", ld_req, 0);
    cyc(20);
    chk("R10 tx_done restored", tx_done, 1);

    // R11: arming used up, new write without read clears nothing
    hold_busy = 1'b1;
    expect_ld(C_DATA, 8'h5A, 1'b0);
    wr_pulse(8'h5A);
    chk("R11 buf_empty kept", buf_empty, 1);
    chk("R11 tx_done kept", tx_done, 1);
    hold_busy = 1'b0;
    cyc(20);

    // R8 R5 R13: enable rising after armed read, long characters
    char_long = 1'b1;
    rd_pulse();
    tx_en = 1'b0; @(negedge clk);
    expect_ld(C_PRE, 8'h5A, 1'b1);
    tx_en = 1'b1; @(negedge clk);
    chk("R8 tx_done cleared by enable", tx_done, 0);
    cyc(20);
    chk("R10 tx_done after preamble", tx_done, 1);

    // R8 R6: break after armed read
    rd_pulse();
    expect_ld(C_BRK, 8'h5A, 1'b1);
    brk_pulse();
    chk("R8 tx_done cleared by break", tx_done, 0);
    cyc(20);
    chk("R6 break loaded", exp_q.size(), 0);

    // R2 R3: overwrite while buffer occupied
    hold_busy = 1'b1;
    rd_pulse();
    wr_pulse(8'h11);
    chk("R2 buf_empty cleared again", buf_empty, 0);
    rd_pulse();
    wr_pulse(8'h22);
    chk("R3 overwrite keeps flag", buf_empty, 0);
    expect_ld(C_DATA, 8'h22, 1'b1);
    hold_busy = 1'b0;
    cyc(20);
    chk("R3 only newest data loaded", exp_q.size(), 0);
    chk("R4 buf_empty set after load", buf_empty, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule